// File: doc/BRIEF.md
# Dimension-Adaptive Route Selector

This block is the route-computation stage of one switch in a network whose switches sit on an L-dimensional lattice, with every switch fully connected to all others that share its coordinates in all but one dimension. For each packet head it compares the switch's own coordinates with the packet's destination coordinates. It reads per-neighbour congestion and link-failure flags and decides the next hop. The decision gives the dimension to move in, the neighbour coordinate within that dimension, whether the packet travels in the adaptive or the escape virtual-channel class, and the packet's updated per-dimension detour permission mask. Packets whose coordinates all match are ejected to a local terminal port.

The decision is made lazily at every hop and separately per dimension. A free minimal hop always wins. Failing that, the packet may take one detour inside a dimension it has not yet detoured in. Only when neither exists does it fall into a dimension-ordered escape class, which it then keeps on later hops. A packet whose last remaining minimal link has failed gets one extra detour. The result is registered one clock after the head is presented.

Top module: `dal_route_unit`

## Requirements
- R1: When every dimension of `here_coord` equals `dest_coord`, the registered result has `route_local`=1 and `route_term`=`dest_term`. The mask, `spare_used_out` and `route_escape` equal the incoming `deroute_mask_in`, `spare_used_in` and `escape_in`.
- R2: A dimension is offset when its coordinates differ. If `escape_in`=0 and some offset dimension d has a minimal neighbour (coordinate `dest_coord` of d) that is neither busy nor dead, the result is a minimal hop. It has `route_dim`=d, `route_coord`=destination coordinate, `route_escape`=0, and the mask unchanged.
- R3: When several dimensions qualify, the unit picks the first qualifying dimension at or above a rotating pointer, wrapping around. The pointer is 0 after reset. After each minimal or detour decision it moves to the chosen dimension plus one, modulo NDIM.
- R4: If no minimal hop is free, the unit considers each offset dimension whose mask bit is 1 and that has a neighbour coordinate that is not here, not the destination, not busy and not dead. Among these it picks a dimension by R3, routes to the lowest such coordinate, and clears that dimension's mask bit only.
- R5: If exactly one dimension is offset, its mask bit is 0, its minimal link is dead and `spare_used_in`=0, that dimension also counts as a detour candidate under R4's neighbour rule. Taking it sets `spare_used_out`=1 and leaves the mask unchanged.
- R6: If no minimal or detour option exists, the result has `route_escape`=1. It routes to the destination coordinate of the lowest-numbered offset dimension, regardless of busy flags, and leaves the mask unchanged.
- R7: A packet with `escape_in`=1 that is not yet at its destination always takes the R6 escape route, even when minimal links are free.
- R8: Results appear one clock after `head_valid`; `route_valid` is a one-cycle copy of `head_valid`. After reset all outputs are 0.
- R9: A neighbour whose `link_dead` bit is 1 is never chosen as a minimal or detour target. The flag vectors index neighbour coordinate c of dimension d at bit d*RADIX+c. Coordinates of dimension d occupy bits d*CW+CW-1 .. d*CW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | A packet head is presented this cycle |
| here_coord | input | NDIM*CW | Coordinates of this switch |
| dest_coord | input | NDIM*CW | Destination switch coordinates |
| dest_term | input | TW | Terminal index at the destination switch |
| deroute_mask_in | input | NDIM | Per-dimension detour permission carried by the packet |
| escape_in | input | 1 | Packet already travels in the escape class |
| spare_used_in | input | 1 | Packet has used its fault detour |
| link_busy | input | NDIM*RADIX | Neighbour blocked by downstream buffer state |
| link_dead | input | NDIM*RADIX | Neighbour link failed |
| route_valid | output | 1 | Registered decision valid |
| route_local | output | 1 | Eject to a local terminal |
| route_term | output | TW | Terminal port for ejection |
| route_dim | output | DW | Chosen dimension |
| route_coord | output | CW | Chosen neighbour coordinate in that dimension |
| route_escape | output | 1 | 1 = escape class, 0 = adaptive class |
| deroute_mask_out | output | NDIM | Updated detour permission mask |
| spare_used_out | output | 1 | Updated fault-detour flag |

## Verification
The hardest case is the fault detour. It needs exactly one offset dimension whose permission bit is already spent, whose minimal link is dead, and a third neighbour in that dimension that is free. Random stimulus rarely lines all of these up, so directed heads build it and then repeat the packet with the spare already consumed to force the escape fall-back. The round-robin pointer is tracked in the bench across every head, including the directed ones, so a long pseudo-random sweep with dense busy flags still predicts which dimension wins.

// File: rtl/dal_pkg.sv
package dal_pkg;
   typedef enum logic [1:0] {
      PICK_LOCAL   = 2'd0,
      PICK_MINIMAL = 2'd1,
      PICK_DETOUR  = 2'd2,
      PICK_ESCAPE  = 2'd3
   } pick_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/dal_dim_slice.sv
module dal_dim_slice #(
   parameter int RADIX = 4,
   parameter int CW    = 2
) (
   input  logic [CW-1:0]    here,
   input  logic [CW-1:0]    dest,
   input  logic [RADIX-1:0] busy,
   input  logic [RADIX-1:0] dead,
   output logic             offset,
   output logic             min_free,
   output logic             min_dead,
   output logic             alt_ok,
   output logic [CW-1:0]    alt_coord
);
   assign offset   = (here != dest);
   assign min_dead = dead[dest];
   assign min_free = offset && !busy[dest] && !dead[dest];

   always_comb begin
      alt_ok    = 1'b0;
      alt_coord = '0;
      for (int c = 0; c < RADIX; c++) begin
         if (!alt_ok && (CW'(c) != here) && (CW'(c) != dest) && !busy[c] && !dead[c]) begin
            alt_ok    = 1'b1;
            alt_coord = CW'(c);
         end
      end
   end
endmodule

// File: rtl/dal_rr_pick.sv
module dal_rr_pick #(
   parameter int N  = 3,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] ptr,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < N; i++) begin : g_scan
         logic [IW:0] j;
         j = {1'b0, ptr} + (IW+1)'(i);
         if (j >= (IW+1)'(N)) j = j - (IW+1)'(N);
         if (!any && req[j[IW-1:0]]) begin
            any = 1'b1;
            idx = j[IW-1:0];
         end
      end
   end
endmodule

// File: rtl/dal_route_unit.sv
module dal_route_unit
   import dal_pkg::*;
#(
   parameter int NDIM  = 3,
   parameter int RADIX = 4,
   parameter int TERMS = 4,
   localparam int CW   = idx_width(RADIX),
   localparam int DW   = idx_width(NDIM),
   localparam int TW   = idx_width(TERMS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  head_valid,
   input  logic [NDIM*CW-1:0]    here_coord,
   input  logic [NDIM*CW-1:0]    dest_coord,
   input  logic [TW-1:0]         dest_term,
   input  logic [NDIM-1:0]       deroute_mask_in,
   input  logic                  escape_in,
   input  logic                  spare_used_in,
   input  logic [NDIM*RADIX-1:0] link_busy,
   input  logic [NDIM*RADIX-1:0] link_dead,
   output logic                  route_valid,
   output logic                  route_local,
   output logic [TW-1:0]         route_term,
   output logic [DW-1:0]         route_dim,
   output logic [CW-1:0]         route_coord,
   output logic                  route_escape,
   output logic [NDIM-1:0]       deroute_mask_out,
   output logic                  spare_used_out
);
   if (NDIM < 1) begin : g_bad_ndim
      $error("NDIM must be at least 1");
   end
   if (RADIX < 3) begin : g_bad_radix
      $error("RADIX must be at least 3 so a detour neighbour exists");
   end
   if (TERMS < 1) begin : g_bad_terms
      $error("TERMS must be at least 1");
   end

   logic [NDIM-1:0] off_v, minfree_v, mindead_v, altok_v;
   logic [CW-1:0]   alt_c [NDIM];

   for (genvar d = 0; d < NDIM; d++) begin : g_dim
      dal_dim_slice #(.RADIX(RADIX), .CW(CW)) u_slice (
         .here      (here_coord[d*CW +: CW]),
         .dest      (dest_coord[d*CW +: CW]),
         .busy      (link_busy[d*RADIX +: RADIX]),
         .dead      (link_dead[d*RADIX +: RADIX]),
         .offset    (off_v[d]),
         .min_free  (minfree_v[d]),
         .min_dead  (mindead_v[d]),
         .alt_ok    (altok_v[d]),
         .alt_coord (alt_c[d])
      );
   end

   logic [DW-1:0]   rr_q;
   logic [NDIM-1:0] der_req, spare_req, adapt_req;
   logic            min_any, adapt_any;
   logic [DW-1:0]   min_idx, adapt_idx, esc_idx;

   assign der_req   = off_v & deroute_mask_in & altok_v;
   assign spare_req = off_v & ~deroute_mask_in & mindead_v & altok_v
                    & {NDIM{$onehot(off_v) & ~spare_used_in}};
   assign adapt_req = der_req | spare_req;

   dal_rr_pick #(.N(NDIM), .IW(DW)) u_pick_min (
      .req(minfree_v), .ptr(rr_q), .any(min_any), .idx(min_idx)
   );
   dal_rr_pick #(.N(NDIM), .IW(DW)) u_pick_adapt (
      .req(adapt_req), .ptr(rr_q), .any(adapt_any), .idx(adapt_idx)
   );

   always_comb begin
      esc_idx = '0;
      for (int d = NDIM-1; d >= 0; d--) begin
         if (off_v[d]) esc_idx = DW'(d);
      end
   end

   pick_e           pick;
   logic [DW-1:0]   nx_dim;
   logic [CW-1:0]   nx_coord;
   logic [NDIM-1:0] nx_mask;
   logic            nx_spare;

   always_comb begin
      nx_mask  = deroute_mask_in;
      nx_spare = spare_used_in;
      nx_dim   = esc_idx;
      if (!(|off_v))          pick = PICK_LOCAL;
      else if (escape_in)     pick = PICK_ESCAPE;
      else if (min_any)       pick = PICK_MINIMAL;
      else if (adapt_any)     pick = PICK_DETOUR;
      else                    pick = PICK_ESCAPE;
      case (pick)
         PICK_MINIMAL: nx_dim = min_idx;
         PICK_DETOUR: begin
            nx_dim = adapt_idx;
            if (der_req[adapt_idx]) nx_mask[adapt_idx] = 1'b0;
            else                    nx_spare = 1'b1;
         end
         default: nx_dim = esc_idx;
      endcase
      nx_coord = (pick == PICK_DETOUR) ? alt_c[nx_dim] : dest_coord[nx_dim*CW +: CW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_q             <= '0;
         route_valid      <= 1'b0;
         route_local      <= 1'b0;
         route_term       <= '0;
         route_dim        <= '0;
         route_coord      <= '0;
         route_escape     <= 1'b0;
         deroute_mask_out <= '0;
         spare_used_out   <= 1'b0;
      end else begin
         route_valid <= head_valid;
         if (head_valid) begin
            route_local      <= (pick == PICK_LOCAL);
            route_term       <= dest_term;
            route_dim        <= nx_dim;
            route_coord      <= nx_coord;
            route_escape     <= (pick == PICK_ESCAPE) || ((pick == PICK_LOCAL) && escape_in);
            deroute_mask_out <= nx_mask;
            spare_used_out   <= nx_spare;
            if (pick == PICK_MINIMAL || pick == PICK_DETOUR)
               rr_q <= (nx_dim == DW'(NDIM-1)) ? '0 : nx_dim + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dal_route_checker.sv
module dal_route_checker #(
   parameter int NDIM  = 3,
   parameter int RADIX = 4,
   parameter int TERMS = 4,
   localparam int CW   = dal_pkg::idx_width(RADIX),
   localparam int DW   = dal_pkg::idx_width(NDIM),
   localparam int TW   = dal_pkg::idx_width(TERMS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  head_valid,
   input logic [NDIM*CW-1:0]    here_coord,
   input logic [NDIM*CW-1:0]    dest_coord,
   input logic [TW-1:0]         dest_term,
   input logic [NDIM-1:0]       deroute_mask_in,
   input logic                  escape_in,
   input logic                  spare_used_in,
   input logic                  route_valid,
   input logic                  route_local,
   input logic [TW-1:0]         route_term,
   input logic                  route_escape,
   input logic [NDIM-1:0]       deroute_mask_out,
   input logic                  spare_used_out
);
   assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid |=> route_valid);
   assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !head_valid |=> !route_valid);
   assert_eject_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && here_coord == dest_coord) |=> (route_local && route_term == $past(dest_term)));
   assert_mask_no_gain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid |=> ((deroute_mask_out & ~$past(deroute_mask_in)) == '0));
   assert_mask_one_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid |=> ($countones(deroute_mask_out ^ $past(deroute_mask_in)) <= 1));
   assert_escape_keeps_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid |=> (!route_escape || deroute_mask_out == $past(deroute_mask_in)));
   assert_escape_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && escape_in) |=> route_escape);
   assert_spare_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (head_valid && spare_used_in) |=> spare_used_out);
endmodule

bind dal_route_unit dal_route_checker #(.NDIM(NDIM), .RADIX(RADIX), .TERMS(TERMS)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .head_valid       (head_valid),
   .here_coord       (here_coord),
   .dest_coord       (dest_coord),
   .dest_term        (dest_term),
   .deroute_mask_in  (deroute_mask_in),
   .escape_in        (escape_in),
   .spare_used_in    (spare_used_in),
   .route_valid      (route_valid),
   .route_local      (route_local),
   .route_term       (route_term),
   .route_escape     (route_escape),
   .deroute_mask_out (deroute_mask_out),
   .spare_used_out   (spare_used_out)
);

// File: tb/dal_route_unit_test.sv
module dal_route_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int NDIM  = 3;
   localparam int RADIX = 4;
   localparam int TERMS = 4;
   localparam int CW = 2;
   localparam int DW = 2;
   localparam int TW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic head_valid = 1'b0;
   logic [NDIM*CW-1:0] here_coord = '0, dest_coord = '0;
   logic [TW-1:0] dest_term = '0;
   logic [NDIM-1:0] deroute_mask_in = '0;
   logic escape_in = 1'b0, spare_used_in = 1'b0;
   logic [NDIM*RADIX-1:0] link_busy = '0, link_dead = '0;
   logic route_valid, route_local, route_escape, spare_used_out;
   logic [TW-1:0] route_term;
   logic [DW-1:0] route_dim;
   logic [CW-1:0] route_coord;
   logic [NDIM-1:0] deroute_mask_out;

   always #(CLK_PERIOD/2) clk = ~clk;

   dal_route_unit #(.NDIM(NDIM), .RADIX(RADIX), .TERMS(TERMS)) uut (
      .clk(clk), .rst_n(rst_n), .head_valid(head_valid),
      .here_coord(here_coord), .dest_coord(dest_coord), .dest_term(dest_term),
      .deroute_mask_in(deroute_mask_in), .escape_in(escape_in), .spare_used_in(spare_used_in),
      .link_busy(link_busy), .link_dead(link_dead),
      .route_valid(route_valid), .route_local(route_local), .route_term(route_term),
      .route_dim(route_dim), .route_coord(route_coord), .route_escape(route_escape),
      .deroute_mask_out(deroute_mask_out), .spare_used_out(spare_used_out)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int rr = 0;
   logic [31:0] seed = 32'h1357_9bdf;

   // expected results
   string e_tag;
   int e_local, e_term, e_dim, e_coord, e_esc, e_mask, e_spare;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rnd();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      return seed;
   endfunction

   function automatic int cget(input logic [NDIM*CW-1:0] v, input int d);
      return int'(v[d*CW +: CW]);
   endfunction

   task automatic model();
      int noff = 0, lowest = -1, pick = -1;
      int off[NDIM], alt[NDIM];
      bit cand[NDIM], isder[NDIM];
      for (int d = 0; d < NDIM; d++) begin
         off[d] = (cget(here_coord, d) != cget(dest_coord, d)) ? 1 : 0;
         noff += off[d];
         if (off[d] == 1 && lowest < 0) lowest = d;
      end
      e_term = int'(dest_term); e_mask = int'(deroute_mask_in); e_spare = int'(spare_used_in);
      e_local = 0; e_esc = 0; e_dim = 0; e_coord = 0;
      if (noff == 0) begin
         e_tag = "R1"; e_local = 1; e_esc = int'(escape_in); return;
      end
      if (escape_in) begin
         e_tag = "R7"; e_esc = 1; e_dim = lowest; e_coord = cget(dest_coord, lowest); return;
      end
      for (int d = 0; d < NDIM; d++) begin
         int t = cget(dest_coord, d);
         cand[d] = off[d] == 1 && !link_busy[d*RADIX+t] && !link_dead[d*RADIX+t];
      end
      for (int i = 0; i < NDIM; i++) begin
         int j = (rr + i) % NDIM;
         if (pick < 0 && cand[j]) pick = j;
      end
      if (pick >= 0) begin
         e_tag = "R2/R3"; e_dim = pick; e_coord = cget(dest_coord, pick);
         rr = (pick + 1) % NDIM; return;
      end
      for (int d = 0; d < NDIM; d++) begin
         int h = cget(here_coord, d), t = cget(dest_coord, d);
         alt[d] = -1;
         for (int c = RADIX-1; c >= 0; c--)
            if (c != h && c != t && !link_busy[d*RADIX+c] && !link_dead[d*RADIX+c]) alt[d] = c;
         isder[d] = off[d] == 1 && deroute_mask_in[d] && alt[d] >= 0;
         cand[d] = isder[d] || (off[d] == 1 && !deroute_mask_in[d] && link_dead[d*RADIX+t]
                   && alt[d] >= 0 && noff == 1 && !spare_used_in);
      end
      for (int i = 0; i < NDIM; i++) begin
         int j = (rr + i) % NDIM;
         if (pick < 0 && cand[j]) pick = j;
      end
      if (pick >= 0) begin
         e_dim = pick; e_coord = alt[pick]; rr = (pick + 1) % NDIM;
         if (isder[pick]) begin e_tag = "R4/R9"; e_mask = e_mask & ~(1 << pick); end
         else begin e_tag = "R5"; e_spare = 1; end
         return;
      end
      e_tag = "R6"; e_esc = 1; e_dim = lowest; e_coord = cget(dest_coord, lowest);
   endtask

   task automatic apply();
      @(negedge clk);
      model();
      head_valid = 1'b1;
      @(negedge clk);
      head_valid = 1'b0;
      chk(e_tag, "route_valid (R8)", int'(route_valid), 1);
      chk(e_tag, "route_local", int'(route_local), e_local);
      chk(e_tag, "route_escape", int'(route_escape), e_esc);
      chk(e_tag, "mask_out", int'(deroute_mask_out), e_mask);
      chk(e_tag, "spare_out", int'(spare_used_out), e_spare);
      if (e_local == 1) chk(e_tag, "route_term", int'(route_term), e_term);
      else begin
         chk(e_tag, "route_dim", int'(route_dim), e_dim);
         chk(e_tag, "route_coord", int'(route_coord), e_coord);
      end
   endtask

   task automatic set_pkt(input logic [NDIM*CW-1:0] h, input logic [NDIM*CW-1:0] t,
                          input logic [NDIM-1:0] m, input bit esc, input bit sp);
      here_coord = h; dest_coord = t; deroute_mask_in = m; escape_in = esc; spare_used_in = sp;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R8", "reset route_valid", int'(route_valid), 0);
      chk("R8", "reset route_escape", int'(route_escape), 0);
      chk("R8", "reset mask_out", int'(deroute_mask_out), 0);
      rst_n = 1'b1;

      // R1: aligned packet ejects
      dest_term = 2'd3;
      set_pkt(6'b10_01_11, 6'b10_01_11, 3'b101, 1'b0, 1'b1);
      apply();
      chk("R1", "eject term", int'(route_term), 3);

      // R3: three offset dims all free, pointer rotates 0,1,2,0
      link_busy = '0; link_dead = '0;
      set_pkt(6'b00_00_00, 6'b11_10_01, 3'b111, 1'b0, 1'b0);
      for (int k = 0; k < 4; k++) begin
         apply();
         chk("R3", "rotating dim", int'(route_dim), k % NDIM);
      end

      // R9: failed minimal link treated as blocked, detour to coord 2
      set_pkt(6'b00_00_00, 6'b00_00_01, 3'b001, 1'b0, 1'b0);
      link_dead = 12'b0000_0000_0010;
      apply();
      chk("R9", "detour coord", int'(route_coord), 2);
      chk("R4", "mask cleared", int'(deroute_mask_out), 0);

      // R5: spare detour then escape once spare is used
      set_pkt(6'b00_00_00, 6'b00_00_01, 3'b000, 1'b0, 1'b0);
      apply();
      chk("R5", "spare set", int'(spare_used_out), 1);
      chk("R5", "spare coord", int'(route_coord), 2);
      set_pkt(6'b00_00_00, 6'b00_00_01, 3'b000, 1'b0, 1'b1);
      apply();
      chk("R6", "escape after spare", int'(route_escape), 1);

      // R6: everything busy
      link_dead = '0; link_busy = '1;
      set_pkt(6'b00_00_00, 6'b11_10_01, 3'b111, 1'b0, 1'b0);
      apply();
      chk("R6", "escape coord", int'(route_coord), 1);

      // R7: escape stays even with free links
      link_busy = '0;
      set_pkt(6'b00_00_00, 6'b11_10_00, 3'b111, 1'b1, 1'b0);
      apply();
      chk("R7", "escape dim", int'(route_dim), 1);

      // R8: valid drops when no head
      @(negedge clk);
      chk("R8", "route_valid low", int'(route_valid), 0);

      // sweep
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] a, b, c;
         a = rnd(); b = rnd(); c = rnd();
         here_coord = a[5:0];
         dest_coord = (a[8:6] == 3'd0) ? a[5:0] : b[5:0];
         if (a[9]) dest_coord[1:0] = here_coord[1:0];
         dest_term = b[7:6];
         deroute_mask_in = b[10:8];
         escape_in = (b[15:12] == 4'd0);
         spare_used_in = b[16];
         case (n % 4)
            0: link_busy = c[11:0] & rnd();
            1: link_busy = c[11:0] | rnd();
            2: link_busy = c[11:0] | rnd() | rnd();
            default: link_busy = c[11:0];
         endcase
         link_dead = c[23:12] & rnd() & ((n % 3 == 0) ? 32'hffff_ffff : rnd());
         apply();
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule